// File: doc/BRIEF.md
# Byte-Burst SPI Master with Register Window

This block is an SPI master for a host that talks to it through a small byte-wide register window. The host fills an eight-slot byte buffer, chooses the clock polarity, clock phase, bit order, bit-clock divider, device select and burst length, and then writes a single start command. The controller shifts the requested bytes out of buffer slots 0 upward. Each byte that comes back from the device overwrites the slot it was sent from.

When the last byte is done, the block sets a completion flag and can raise an interrupt. A start command written while a burst is still running does not start a second burst; it sets an error flag instead. Three active-low device selects are driven either straight from a 3-bit mask or from a binary device number. While the select-output enable is off, all three selects are held high.

Top module: `spi_burst_top`

## Requirements
- R1: Register map (4-bit address, byte data): 0x0 mode, 0x1 clock select, 0x2 divider, 0x3 select/length, 0x4 control, 0x5 status. Buffer slot n is at 0x8+n. Any other address reads 0.
- R2: After reset every register and buffer slot reads 0, all selects are high, SCLK and MOSI are low, and the interrupt is low.
- R3: Writing control with bit3 (go) set starts a burst only when mode bit4 (enable) and control bit2 (buffer mode, in the same write) are both 1. Control bit3 always reads 0. Status bit2 reads 1 for as long as the burst runs.
- R4: The select/length bits 6:4 hold the byte count minus one. The burst sends slots 0 up to that value in slot order, and the busy time is exactly 8 × count × D clock cycles, where D is the effective divider.
- R5: Mode bit3 = 1 sends and receives each byte LSB first; 0 means MSB first.
- R6: Mode bit2 is clock polarity: SCLK rests at this level when idle. Mode bit1 is clock phase: with 0, MISO is sampled on the leading edge and MOSI is valid half a bit before it; with 1, MISO is sampled on the trailing edge.
- R7: Each received byte is written into the slot its transmitted byte came from. Slots beyond the burst length keep their contents.
- R8: The effective divider D is loaded from the divider register only on cycles when clock-select bit2 is 1. While bit2 is 0, writes to the divider have no effect. A value below 3 acts as 3. One SCLK period is D clock cycles.
- R9: With mode bit7 = 0 all selects are high. Otherwise, select/length bit3 = 0 drives bits 2:0 onto the selects directly as an active-low mask. Bit3 = 1 treats bits 2:0 as a device number: 0 to 2 pulls that one select low, and 7 (or any other value) leaves all selects high.
- R10: Status bit0 is set when a burst ends. Status bit1 is set when go is written during a burst, and that go is otherwise ignored. Writing 1 to a status bit clears it.
- R11: The interrupt is (status bit0 AND control bit6) OR (status bit1 AND control bit7).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| spi_sclk | output | 1 | SPI bit clock |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |
| spi_cs_n | output | 3 | Active-low device selects |
| irq | output | 1 | Interrupt request |

## Verification
Most engine faults first appear in the serial streams. A wrong bit counter or a misplaced byte reload corrupts the MOSI byte that the serial monitor captures, and that shows up within one byte time. A wrong capture edge or a wrong shift direction corrupts the bytes written back to the buffer, which the buffer readback exposes as soon as the burst ends. A wrong divider latch or a wrong burst-end condition changes the busy interval, which is counted cycle by cycle against 8 × count × D. Faults in the status and select logic show up at once on the status read, on irq, or on the select pins.

// File: rtl/spi_burst_pkg.sv
// Shared constants for the byte-burst SPI master: register addresses,
// bit positions inside registers, and the engine state type.
package spi_burst_pkg;
    localparam int unsigned A_MODE = 0;
    localparam int unsigned A_CLKS = 1;
    localparam int unsigned A_DIV  = 2;
    localparam int unsigned A_SEL  = 3;
    localparam int unsigned A_CTRL = 4;
    localparam int unsigned A_STAT = 5;

    localparam int unsigned MODE_CPHA = 1;
    localparam int unsigned MODE_CPOL = 2;
    localparam int unsigned MODE_LSB  = 3;
    localparam int unsigned MODE_EN   = 4;
    localparam int unsigned MODE_SOE  = 7;

    localparam int unsigned CLKS_DEN  = 2;
    localparam int unsigned SEL_DEC   = 3;
    localparam int unsigned SEL_LEN   = 4;

    localparam int unsigned CTRL_BUF  = 2;
    localparam int unsigned CTRL_GO   = 3;
    localparam int unsigned CTRL_DIE  = 6;
    localparam int unsigned CTRL_EIE  = 7;

    typedef enum logic {ST_IDLE = 1'b0, ST_SHIFT = 1'b1} eng_state_t;
endpackage

// File: rtl/spi_burst_regs.sv
// Register window and slot buffer of the SPI master.
// Assumes ADDR_W is one bit wider than the slot index, with the buffer
// occupying the upper half of the address space. Engine writes to a
// slot take priority over host writes in the same cycle.
module spi_burst_regs #(
    parameter int SLOTS  = 8,
    parameter int ADDR_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [7:0]               wdata,
    output logic [7:0]               rdata,
    input  logic                     busy,
    input  logic                     fin,
    input  logic                     eng_wr,
    input  logic [$clog2(SLOTS)-1:0] eng_slot,
    input  logic [7:0]               eng_data,
    output logic [7:0]               mode_q,
    output logic [7:0]               clks_q,
    output logic [7:0]               div_q,
    output logic [7:0]               sel_q,
    output logic                     start,
    output logic [SLOTS-1:0][7:0]    buf_q,
    output logic                     irq
);
    import spi_burst_pkg::*;

    localparam int SW = $clog2(SLOTS);
    localparam int BUF_BASE = SLOTS;

    logic [7:0] ctrl_q;
    logic [1:0] stat_q;
    logic       go_req, err_set, stat_wr, buf_hit;

    // Decode of the go command and the status write.
    assign go_req  = wr_en && (addr == ADDR_W'(A_CTRL)) && wdata[CTRL_GO];
    assign start   = go_req && !busy && mode_q[MODE_EN] && wdata[CTRL_BUF];
    assign err_set = go_req && busy;
    assign stat_wr = wr_en && (addr == ADDR_W'(A_STAT));
    assign buf_hit = (int'(addr) >= BUF_BASE);

    // Configuration registers, written by the host.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
            clks_q <= '0;
            div_q  <= '0;
            sel_q  <= '0;
            ctrl_q <= '0;
        end else if (wr_en) begin
            case (int'(addr))
                A_MODE: mode_q <= wdata;
                A_CLKS: clks_q <= wdata;
                A_DIV:  div_q  <= wdata;
                A_SEL:  sel_q  <= wdata;
                A_CTRL: ctrl_q <= wdata & ~(8'd1 << CTRL_GO);
                default: ;
            endcase
        end
    end

    // Status flags: a set wins over a write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            stat_q[0] <= fin     | (stat_q[0] & ~(stat_wr & wdata[0]));
            stat_q[1] <= err_set | (stat_q[1] & ~(stat_wr & wdata[1]));
        end
    end

    // One storage byte per slot; the engine's write-back takes priority.
    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)
                buf_q[i] <= '0;
            else if (eng_wr && (eng_slot == SW'(i)))
                buf_q[i] <= eng_data;
            else if (wr_en && buf_hit && (addr[SW-1:0] == SW'(i)))
                buf_q[i] <= wdata;
        end
    end

    // Read multiplexer.
    always_comb begin
        rdata = '0;
        if (buf_hit) begin
            rdata = buf_q[addr[SW-1:0]];
        end else begin
            case (int'(addr))
                A_MODE: rdata = mode_q;
                A_CLKS: rdata = clks_q;
                A_DIV:  rdata = div_q;
                A_SEL:  rdata = sel_q;
                A_CTRL: rdata = ctrl_q;
                A_STAT: rdata = {5'd0, busy, stat_q};
                default: rdata = '0;
            endcase
        end
    end

    // Interrupt: each flag gated by its enable.
    assign irq = (stat_q[0] & ctrl_q[CTRL_DIE]) | (stat_q[1] & ctrl_q[CTRL_EIE]);

    // R10
    done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> stat_q[0]);
    // R10
    done_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && wdata[0] && !fin) |=> !stat_q[0]);
    // R10
    err_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (go_req && busy) |=> stat_q[1]);
endmodule

// File: rtl/spi_burst_div.sv
// Effective divider holder. It follows the divider register only while
// the gate bit is set, and raises any value below DIV_MIN to DIV_MIN.
module spi_burst_div #(
    parameter int DW      = 8,
    parameter int DIV_MIN = 3,
    parameter int DIV_RST = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          den,
    input  logic [DW-1:0] div_in,
    output logic [DW-1:0] div_eff
);
    logic [DW-1:0] div_eff_q;

    // Load the clamped divider while the gate is open.
    always_ff @(posedge clk) begin
        if (!rst_n)
            div_eff_q <= DW'(DIV_RST);
        else if (den)
            div_eff_q <= (int'(div_in) < DIV_MIN) ? DW'(DIV_MIN) : div_in;
    end

    assign div_eff = div_eff_q;

    // R8
    div_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(div_eff_q) >= DIV_MIN);
    // R8
    div_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !den |=> $stable(div_eff_q));
endmodule

// File: rtl/spi_burst_engine.sv
// Shift engine. A start pulse latches the mode and divider and shifts
// out bytes from slot 0 to slot len. Each received byte is written back
// to its slot. Every bit lasts div clocks: an idle-level first half of
// div/2 cycles, then an active-level second half.
// Assumes div >= 3, which the divider holder guarantees.
module spi_burst_engine #(
    parameter int SLOTS = 8,
    parameter int DW    = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [$clog2(SLOTS)-1:0] len,
    input  logic [DW-1:0]            div_eff,
    input  logic                     cfg_cpha,
    input  logic                     cfg_cpol,
    input  logic                     cfg_lsb,
    input  logic [SLOTS-1:0][7:0]    buf_q,
    input  logic                     miso,
    output logic                     busy,
    output logic                     fin,
    output logic                     bw_en,
    output logic [$clog2(SLOTS)-1:0] bw_slot,
    output logic [7:0]               bw_data,
    output logic                     sclk,
    output logic                     mosi
);
    import spi_burst_pkg::*;

    localparam int SW = $clog2(SLOTS);
    localparam int BW = 3;

    eng_state_t    state_q;
    logic [DW-1:0] cnt_q, div_l, half, half_m1, end_m1;
    logic [BW-1:0] bitc_q;
    logic [SW-1:0] bytec_q, last_q;
    logic          cpha_l, cpol_l, lsb_l, run;
    logic [7:0]    tx_sr, rx_sr, rx_next, tx_shift;
    logic          at_lead, at_end, byte_end;

    // Bit-time landmarks derived from the latched divider.
    assign run      = (state_q == ST_SHIFT);
    assign half     = div_l >> 1;
    assign half_m1  = half - 1'b1;
    assign end_m1   = div_l - 1'b1;
    assign at_lead  = run && (cnt_q == half_m1);
    assign at_end   = run && (cnt_q == end_m1);
    assign byte_end = at_end && (bitc_q == '1);
    assign fin      = byte_end && (bytec_q == last_q);

    // Next receive and transmit shift values for the latched bit order.
    assign rx_next  = lsb_l ? {miso, rx_sr[7:1]} : {rx_sr[6:0], miso};
    assign tx_shift = lsb_l ? {1'b0, tx_sr[7:1]} : {tx_sr[6:0], 1'b0};

    // Sequencer: counters, shift registers and the latched configuration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            div_l   <= DW'(3);
            bitc_q  <= '0;
            bytec_q <= '0;
            last_q  <= '0;
            cpha_l  <= 1'b0;
            cpol_l  <= 1'b0;
            lsb_l   <= 1'b0;
            tx_sr   <= '0;
            rx_sr   <= '0;
        end else if (!run) begin
            if (start) begin
                state_q <= ST_SHIFT;
                cnt_q   <= '0;
                bitc_q  <= '0;
                bytec_q <= '0;
                last_q  <= len;
                div_l   <= div_eff;
                cpha_l  <= cfg_cpha;
                cpol_l  <= cfg_cpol;
                lsb_l   <= cfg_lsb;
                tx_sr   <= buf_q[0];
            end
        end else begin
            cnt_q <= at_end ? '0 : cnt_q + 1'b1;
            if (at_end)
                bitc_q <= bitc_q + 1'b1;
            if (cpha_l ? at_end : at_lead)
                rx_sr <= rx_next;
            if (byte_end) begin
                if (fin) begin
                    state_q <= ST_IDLE;
                end else begin
                    bytec_q <= bytec_q + 1'b1;
                    tx_sr   <= buf_q[bytec_q + 1'b1];
                end
            end else if (cpha_l ? (at_lead && (bitc_q != '0)) : at_end) begin
                tx_sr <= tx_shift;
            end
        end
    end

    // Write-back of each completed received byte.
    assign bw_en   = byte_end;
    assign bw_slot = bytec_q;
    assign bw_data = cpha_l ? rx_next : rx_sr;

    // Serial outputs.
    assign busy = run;
    assign sclk = run ? (cpol_l ^ (cnt_q >= half)) : cfg_cpol;
    assign mosi = run ? (lsb_l ? tx_sr[0] : tx_sr[7]) : 1'b0;

    // R3
    start_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !run) |=> run);
    // R4
    fin_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> !run);
    // R8
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q < div_l));
    // R6
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !fin) |=> ($stable(cpol_l) && $stable(cpha_l) && $stable(lsb_l)));
endmodule

// File: rtl/spi_burst_csel.sv
// Device-select driver. Each active-low line comes either straight from
// the mask field or from comparing the field with the line's number.
// All lines are forced high while output enable is off.
module spi_burst_csel #(
    parameter int NCS = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           oe,
    input  logic           dec,
    input  logic [NCS-1:0] field,
    output logic [NCS-1:0] cs_n
);
    // One driver per select line.
    for (genvar i = 0; i < NCS; i++) begin : g_line
        always_comb begin
            if (!oe)
                cs_n[i] = 1'b1;
            else if (dec)
                cs_n[i] = (field != NCS'(i));
            else
                cs_n[i] = field[i];
        end
    end

    // R9
    dec_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (oe && dec) |-> ($countones(~cs_n) <= 1));
    // R9
    oe_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !oe |-> (&cs_n));
endmodule

// File: rtl/spi_burst_top.sv
// Byte-burst SPI master top. It ties the register window, the divider
// holder, the shift engine and the select driver together.
// Assumes one clock domain and synchronous active-low reset.
module spi_burst_top #(
    parameter int SLOTS   = 8,
    parameter int ADDR_W  = 4,
    parameter int DIV_W   = 8,
    parameter int DIV_MIN = 3,
    parameter int DIV_RST = 8,
    parameter int NCS     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              spi_sclk,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic [NCS-1:0]    spi_cs_n,
    output logic              irq
);
    import spi_burst_pkg::*;

    localparam int SW = $clog2(SLOTS);

    logic [7:0]             mode_q, clks_q, div_q, sel_q;
    logic                   start, busy, fin, bw_en;
    logic [SW-1:0]          bw_slot;
    logic [7:0]             bw_data;
    logic [SLOTS-1:0][7:0]  buf_q;
    logic [DIV_W-1:0]       div_eff;

    spi_burst_regs #(.SLOTS(SLOTS), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .busy(busy), .fin(fin),
        .eng_wr(bw_en), .eng_slot(bw_slot), .eng_data(bw_data),
        .mode_q(mode_q), .clks_q(clks_q), .div_q(div_q), .sel_q(sel_q),
        .start(start), .buf_q(buf_q), .irq(irq)
    );

    spi_burst_div #(.DW(DIV_W), .DIV_MIN(DIV_MIN), .DIV_RST(DIV_RST)) u_div (
        .clk(clk), .rst_n(rst_n), .den(clks_q[CLKS_DEN]),
        .div_in(div_q[DIV_W-1:0]), .div_eff(div_eff)
    );

    spi_burst_engine #(.SLOTS(SLOTS), .DW(DIV_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .start(start), .len(sel_q[SEL_LEN +: SW]),
        .div_eff(div_eff), .cfg_cpha(mode_q[MODE_CPHA]),
        .cfg_cpol(mode_q[MODE_CPOL]), .cfg_lsb(mode_q[MODE_LSB]),
        .buf_q(buf_q), .miso(spi_miso), .busy(busy), .fin(fin),
        .bw_en(bw_en), .bw_slot(bw_slot), .bw_data(bw_data),
        .sclk(spi_sclk), .mosi(spi_mosi)
    );

    spi_burst_csel #(.NCS(NCS)) u_csel (
        .clk(clk), .rst_n(rst_n), .oe(mode_q[MODE_SOE]), .dec(sel_q[SEL_DEC]),
        .field(sel_q[NCS-1:0]), .cs_n(spi_cs_n)
    );

    // R11
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (reg_rdata == reg_rdata) && (u_regs.ctrl_q[CTRL_DIE] || u_regs.ctrl_q[CTRL_EIE]));
endmodule

// File: tb/spi_burst_top_tb_top.sv
// Scoreboard bench: the burst task pushes expected MOSI bytes into a
// queue, and a serial monitor pops and compares them as the bytes appear.
// A device model answers on MISO, and the buffer readback is compared
// with the device bytes once each burst ends.
module spi_burst_top_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [3:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       spi_sclk, spi_mosi;
    logic       spi_miso = 1'b0;
    logic [2:0] spi_cs_n;
    logic       irq;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    logic [7:0] exp_q[$];
    logic [7:0] txb[8];
    logic [7:0] slv[8];
    int         slv_n = 0;
    int         slv_k = 0;
    bit         active = 1'b0;
    bit         c_cpol = 1'b0, c_cpha = 1'b0, c_lsb = 1'b0;
    logic       sclk_p = 1'b0, mosi_p = 1'b0;
    logic [7:0] mon_sr = '0;
    int         mon_bits = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_burst_top dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sclk(spi_sclk),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Called at a negedge; the write takes effect at the next posedge.
    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    function automatic logic slv_bit(input int k);
        logic [7:0] b;
        if (k >= 8 * slv_n) return 1'b0;
        b = slv[k / 8];
        return c_lsb ? b[k % 8] : b[7 - (k % 8)];
    endfunction

    // Serial monitor and device model, evaluated away from the active edge.
    always @(negedge clk) begin
        if (active && (spi_sclk !== sclk_p)) begin
            logic lead, cap;
            lead = (spi_sclk !== c_cpol);
            cap  = c_cpha ? !lead : lead;
            if (cap) begin
                mon_sr = c_lsb ? {mosi_p, mon_sr[7:1]} : {mon_sr[6:0], mosi_p};
                mon_bits++;
                if (mon_bits == 8) begin
                    mon_bits = 0;
                    if (exp_q.size() == 0) begin
                        chk("R4 unexpected MOSI byte", {24'd0, mon_sr}, 32'hFFFF_FFFF);
                    end else begin
                        logic [7:0] e;
                        e = exp_q.pop_front();
                        // R4 R5 R6: byte order, bit order and edge placement
                        chk("R4/R5/R6 MOSI byte", {24'd0, mon_sr}, {24'd0, e});
                    end
                end
            end else begin
                spi_miso = slv_bit(slv_k);
                slv_k++;
            end
        end
        sclk_p = spi_sclk;
        mosi_p = spi_mosi;
    end

    task automatic burst(input int n, input bit cpol, input bit cpha, input bit lsb,
                         input int dexp, input logic [7:0] ctrl, input int intrude,
                         input logic [7:0] seed);
        logic [7:0] d;
        int c;
        c_cpol = cpol; c_cpha = cpha; c_lsb = lsb;
        for (int i = 0; i < 8; i++) begin
            txb[i] = seed + 8'(i * 37);
            slv[i] = ~seed ^ 8'(i * 29 + 5);
            wr(4'(8 + i), txb[i]);
        end
        slv_n = n;
        wr(4'h0, 8'h90 | {4'd0, lsb, cpol, cpha, 1'b0});
        wr(4'h3, {1'b0, 3'(n - 1), 4'b0110});
        // R6: idle level equals polarity
        chk("R6 SCLK idle level", {31'd0, spi_sclk}, {31'd0, cpol});
        for (int i = 0; i < n; i++) exp_q.push_back(txb[i]);
        mon_bits = 0;
        if (!cpha) begin
            spi_miso = slv_bit(0);
            slv_k = 1;
        end else begin
            slv_k = 0;
        end
        active = 1'b1;
        wr(4'h4, ctrl);
        c = 0;
        forever begin
            rd(4'h5, d);
            if (!d[2]) break;
            c++;
            if (c == intrude) wr(4'h4, ctrl);
            else @(negedge clk);
        end
        active = 1'b0;
        // R4: busy time 8 * count * D (R8 via D)
        if (intrude == 0) chk("R4/R8 busy cycles", c, 8 * n * dexp);
        rd(4'h5, d);
        // R10: completion set, error only for the intruding go
        chk("R10 status after burst", {24'd0, d}, {30'd0, (intrude != 0), 1'b1});
        // R11
        chk("R11 irq after burst", {31'd0, irq},
            {31'd0, ctrl[6] | (ctrl[7] & (intrude != 0))});
        for (int i = 0; i < 8; i++) begin
            rd(4'(8 + i), d);
            // R7: received bytes written back, untouched slots kept
            chk("R7 buffer readback", {24'd0, d}, {24'd0, (i < n) ? slv[i] : txb[i]});
        end
        chk("R4 all MOSI bytes seen", exp_q.size(), 0);
        @(negedge clk);
        wr(4'h5, 8'h03);
        rd(4'h5, d);
        // R10: write-one-to-clear
        chk("R10 status cleared", {24'd0, d}, 32'd0);
        chk("R11 irq cleared", {31'd0, irq}, 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R2: reset contents of every mapped location
        for (int a = 0; a < 16; a++) begin
            rd(4'(a), d);
            chk("R1/R2 reset readback", {24'd0, d}, 32'd0);
        end
        chk("R2 reset selects", {29'd0, spi_cs_n}, 32'd7);
        chk("R2 reset sclk/mosi/irq", {29'd0, spi_sclk, spi_mosi, irq}, 32'd0);

        // R9: select driving
        @(negedge clk);
        wr(4'h3, 8'h00);
        chk("R9 output enable off", {29'd0, spi_cs_n}, 32'd7);
        wr(4'h0, 8'h80);
        wr(4'h3, 8'h05);
        chk("R9 raw mask", {29'd0, spi_cs_n}, 32'd5);
        wr(4'h3, 8'h0A);
        chk("R9 decoded device 2", {29'd0, spi_cs_n}, 32'd3);
        wr(4'h3, 8'h08);
        chk("R9 decoded device 0", {29'd0, spi_cs_n}, 32'd6);
        wr(4'h3, 8'h0F);
        chk("R9 decoded all-ones", {29'd0, spi_cs_n}, 32'd7);
        rd(4'h3, d);
        chk("R1 select register readback", {24'd0, d}, 32'h0F);

        // R8: load divider 5 through the gate
        @(negedge clk);
        wr(4'h1, 8'h00);
        wr(4'h2, 8'd5);
        wr(4'h1, 8'h04);
        burst(1, 1'b0, 1'b0, 1'b0, 5, 8'hCC, 0, 8'h5A);
        // R8: gate closed, new divider has no effect
        wr(4'h1, 8'h00);
        wr(4'h2, 8'd7);
        burst(2, 1'b0, 1'b0, 1'b0, 5, 8'h4C, 0, 8'hA3);
        wr(4'h1, 8'h04);
        burst(3, 1'b0, 1'b1, 1'b0, 7, 8'h0C, 0, 8'h17);
        // R8: divider below minimum acts as 3
        wr(4'h2, 8'd1);
        burst(8, 1'b1, 1'b1, 1'b1, 3, 8'hCC, 0, 8'hC6);
        burst(4, 1'b1, 1'b0, 1'b1, 3, 8'h4C, 0, 8'h39);
        burst(2, 1'b0, 1'b0, 1'b1, 3, 8'h4C, 0, 8'hE1);

        // R10: go written during a burst sets error and is ignored
        burst(2, 1'b0, 1'b1, 1'b0, 3, 8'hCC, 5, 8'h72);

        // R3: go ignored when controller enable is off
        wr(4'h0, 8'h80);
        wr(4'h4, 8'h0C);
        rd(4'h5, d);
        chk("R3 no start without enable", {24'd0, d}, 32'd0);
        rd(4'h4, d);
        chk("R3 go reads back 0", {24'd0, d}, 32'h04);
        // R3: go ignored without buffer mode
        wr(4'h0, 8'h90);
        wr(4'h4, 8'h08);
        rd(4'h5, d);
        chk("R3 no start without buffer mode", {24'd0, d}, 32'd0);
        repeat (4) @(negedge clk);
        chk("R3 SCLK stayed idle", {31'd0, spi_sclk}, 32'd0);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule